// File: doc/BRIEF.md
# Vector Length Configuration Unit

This block performs the configuration step that precedes vector work. A requester presents an application element count together with an 8-bit packed type immediate. The unit unpacks the immediate into an element width, a register-group multiplier (integer or fractional) and two policy flags. From these it derives the largest element count the hardware can hold, given the register width `VLEN`. It returns the smaller of that maximum and the requested count as the granted vector length.

The granted length and the illegal flag are combinational from the request, so they can be written to a scalar destination in the same cycle. On the clock edge after a valid request, the granted length and the decoded type are committed to configuration state. A rejected immediate leaves the committed type as it was and commits a length of zero. A combinational alignment check compares a register-group base number against the committed multiplier.

Top module: `vcfg_unit`

## Requirements
- R1: After reset, the committed length is 0, the element-width code is 000, the multiplier code is 000, and both policy flags are 0.
- R2: For multiplier codes 000/001/010/011 (group of 1/2/4/8 registers) and element-width codes 000/001/010/011 (8/16/32/64 bits), the granted length `rd_vl` is min(request, (VLEN/width) × group). For example, VLEN=256 with code 010 (32 bits), group 1 and a request of 100 grants 8.
- R3: Multiplier codes 101/110/111 are fractions 1/8, 1/4 and 1/2. The maximum is VLEN/(width × divisor). When that maximum is zero, `req_illegal` is 1 and `rd_vl` is 0.
- R4: An immediate with multiplier code 100, or with bit 5 set (element-width code 1xx), is reserved. It raises `req_illegal` and forces `rd_vl` to 0.
- R5: After a valid request that is not illegal, the next clock edge commits: `cfg_vl` = granted length, the element-width code = immediate bits [5:3], the multiplier code = bits [2:0], tail flag = bit 6, mask flag = bit 7.
- R6: After a valid illegal request, the next clock edge sets `cfg_vl` to 0 and leaves the committed type fields unchanged.
- R7: While `req_valid` is low, all committed state holds its value.
- R8: A request of zero grants 0, and the request is not illegal for that reason.
- R9: `grp_aligned` is 1 when the committed multiplier code is 001, 010 or 011 and `grp_base` is a multiple of 2, 4 or 8 respectively. For any other committed code, `grp_aligned` is 1 for every base.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Active-low asynchronous reset |
| req_valid | input | 1 | Request commits on the next edge |
| req_avl | input | AVL_W | Requested element count |
| req_vtype | input | 8 | Packed type immediate |
| rd_vl | output | VL_W | Granted length for the scalar destination |
| req_illegal | output | 1 | Immediate reserved or maximum zero |
| cfg_vl | output | VL_W | Committed vector length |
| cfg_sew_code | output | 3 | Committed element-width code |
| cfg_lmul_code | output | 3 | Committed multiplier code |
| cfg_tail_agn | output | 1 | Committed tail policy flag |
| cfg_mask_agn | output | 1 | Committed mask policy flag |
| grp_base | input | REG_IDX_W | Register-group base number to check |
| grp_aligned | output | 1 | Base is legal for the committed multiplier |

## Verification
The properties assume that `req_valid`, `req_avl` and `req_vtype` are driven to known values from the first clock. They also assume these inputs are stable around each rising edge, because the commit properties compare the state after an edge with the request sampled at that edge. The bench drives every input just after a falling edge, holds it through the next rising edge, and keeps `req_valid` low through reset. It then sweeps all 256 immediates with requests at zero, at one, and at the maximum, one below it and one above it.

// File: rtl/vcfg_pkg.sv
package vcfg_pkg;
   localparam logic [2:0] LMUL_RSV = 3'b100;

   typedef struct packed {
      logic       mask_agn;
      logic       tail_agn;
      logic [2:0] sew_code;
      logic [2:0] lmul_code;
   } vtype_t;

   function automatic logic lmul_is_frac(input logic [2:0] code);
      return code[2] && (code != LMUL_RSV);
   endfunction

   // right shift that turns VLEN into the per-register count, plus fraction
   function automatic int unsigned max_rshift(input logic [1:0] sew, input logic [2:0] lm);
      int unsigned r;
      r = 32'(sew) + 3;
      if (lmul_is_frac(lm)) r = r + 8 - 32'(lm);
      return r;
   endfunction

   function automatic int unsigned max_lshift(input logic [2:0] lm);
      return lm[2] ? 0 : 32'(lm[1:0]);
   endfunction
endpackage

// File: rtl/vcfg_type_decode.sv
module vcfg_type_decode
   import vcfg_pkg::*;
(
   input  logic [7:0] imm,
   output vtype_t     fields,
   output logic       reserved
);
   always_comb begin
      fields.lmul_code = imm[2:0];
      fields.sew_code  = imm[5:3];
      fields.tail_agn  = imm[6];
      fields.mask_agn  = imm[7];
      reserved         = (imm[2:0] == LMUL_RSV) || imm[5];
   end
endmodule

// File: rtl/vcfg_vlmax.sv
module vcfg_vlmax
   import vcfg_pkg::*;
#(
   parameter int unsigned VLEN  = 256,
   parameter int unsigned STYLE = 0,   // 0: shifter, 1: constant table
   localparam int unsigned VL_W = $clog2(VLEN) + 1
) (
   input  logic [1:0]      sew,
   input  logic [2:0]      lmul,
   output logic [VL_W-1:0] vlmax
);
   if (STYLE == 0) begin : g_shift
      logic [3:0]      rsh;
      logic [1:0]      lsh;
      logic [VL_W-1:0] per_reg;
      always_comb begin
         rsh     = 4'(max_rshift(sew, lmul));
         lsh     = 2'(max_lshift(lmul));
         per_reg = VL_W'(VLEN) >> rsh;
         vlmax   = (lmul == LMUL_RSV) ? '0 : (per_reg << lsh);
      end
   end else begin : g_table
      logic [VL_W-1:0] tbl [32];
      for (genvar s = 0; s < 4; s++) begin : g_s
         for (genvar l = 0; l < 8; l++) begin : g_l
            localparam int unsigned RS = (l >= 5) ? (s + 3 + 8 - l) : (s + 3);
            localparam int unsigned LS = (l < 4) ? l : 0;
            localparam int unsigned V  = (l == 4) ? 0 : ((VLEN >> RS) << LS);
            assign tbl[s*8 + l] = VL_W'(V);
         end
      end
      assign vlmax = tbl[{sew, lmul}];
   end
endmodule

// File: rtl/vcfg_vl_clip.sv
module vcfg_vl_clip #(
   parameter int unsigned AVL_W = 32,
   parameter int unsigned VL_W  = 9,
   localparam int unsigned CW   = (AVL_W > VL_W) ? AVL_W : VL_W
) (
   input  logic [AVL_W-1:0] avl,
   input  logic [VL_W-1:0]  vlmax,
   input  logic             kill,
   output logic [VL_W-1:0]  vl
);
   logic [CW-1:0] a_ext, m_ext;
   always_comb begin
      a_ext = CW'(avl);
      m_ext = CW'(vlmax);
      if (kill)               vl = '0;
      else if (a_ext < m_ext) vl = VL_W'(a_ext);
      else                    vl = vlmax;
   end
endmodule

// File: rtl/vcfg_group_check.sv
module vcfg_group_check #(
   parameter int unsigned REG_IDX_W = 5
) (
   input  logic [2:0]           lmul,
   input  logic [REG_IDX_W-1:0] base,
   output logic                 aligned
);
   logic [3:0] ok_by_code;
   assign ok_by_code[0] = 1'b1;
   for (genvar k = 1; k < 4; k++) begin : g_mult
      assign ok_by_code[k] = (base[k-1:0] == '0);
   end
   assign aligned = lmul[2] ? 1'b1 : ok_by_code[lmul[1:0]];
endmodule

// File: rtl/vcfg_unit.sv
module vcfg_unit
   import vcfg_pkg::*;
#(
   parameter int unsigned VLEN        = 256,
   parameter int unsigned AVL_W       = 32,
   parameter int unsigned REG_IDX_W   = 5,
   parameter int unsigned VLMAX_STYLE = 0,
   localparam int unsigned VL_W       = $clog2(VLEN) + 1
) (
   input  logic                 clk,
   input  logic                 rst_n,
   input  logic                 req_valid,
   input  logic [AVL_W-1:0]     req_avl,
   input  logic [7:0]           req_vtype,
   output logic [VL_W-1:0]      rd_vl,
   output logic                 req_illegal,
   output logic [VL_W-1:0]      cfg_vl,
   output logic [2:0]           cfg_sew_code,
   output logic [2:0]           cfg_lmul_code,
   output logic                 cfg_tail_agn,
   output logic                 cfg_mask_agn,
   input  logic [REG_IDX_W-1:0] grp_base,
   output logic                 grp_aligned
);
   if (VLEN < 128 || (VLEN & (VLEN - 1)) != 0) begin : g_bad_vlen
      $error("vcfg_unit: VLEN must be a power of two of at least 128");
   end
   if (REG_IDX_W < 3) begin : g_bad_idx
      $error("vcfg_unit: REG_IDX_W must cover a group of eight");
   end
   if (VLMAX_STYLE > 1) begin : g_bad_style
      $error("vcfg_unit: VLMAX_STYLE must be 0 or 1");
   end

   vtype_t          dec;
   logic            rsv;
   logic [VL_W-1:0] vlmax;
   logic            kill;
   vtype_t          cfg_q;
   logic [VL_W-1:0] vl_q;

   vcfg_type_decode u_dec (
      .imm      (req_vtype),
      .fields   (dec),
      .reserved (rsv)
   );

   vcfg_vlmax #(.VLEN(VLEN), .STYLE(VLMAX_STYLE)) u_max (
      .sew   (dec.sew_code[1:0]),
      .lmul  (dec.lmul_code),
      .vlmax (vlmax)
   );

   assign kill        = rsv || (vlmax == '0);
   assign req_illegal = kill;

   vcfg_vl_clip #(.AVL_W(AVL_W), .VL_W(VL_W)) u_clip (
      .avl   (req_avl),
      .vlmax (vlmax),
      .kill  (kill),
      .vl    (rd_vl)
   );

   always_ff @(posedge clk or negedge rst_n) begin
      if (!rst_n) begin
         vl_q  <= '0;
         cfg_q <= '0;
      end else if (req_valid) begin
         vl_q <= rd_vl;
         if (!kill) cfg_q <= dec;
      end
   end

   assign cfg_vl        = vl_q;
   assign cfg_sew_code  = cfg_q.sew_code;
   assign cfg_lmul_code = cfg_q.lmul_code;
   assign cfg_tail_agn  = cfg_q.tail_agn;
   assign cfg_mask_agn  = cfg_q.mask_agn;

   vcfg_group_check #(.REG_IDX_W(REG_IDX_W)) u_grp (
      .lmul    (cfg_q.lmul_code),
      .base    (grp_base),
      .aligned (grp_aligned)
   );
endmodule

// File: rtl/vcfg_unit_chk.sv
module vcfg_unit_chk #(
   parameter int unsigned VLEN      = 256,
   parameter int unsigned AVL_W     = 32,
   parameter int unsigned REG_IDX_W = 5,
   localparam int unsigned VL_W     = $clog2(VLEN) + 1,
   localparam int unsigned CW       = (AVL_W > VL_W) ? AVL_W : VL_W
) (
   input logic                 clk,
   input logic                 rst_n,
   input logic                 req_valid,
   input logic [AVL_W-1:0]     req_avl,
   input logic [7:0]           req_vtype,
   input logic [VL_W-1:0]      rd_vl,
   input logic                 req_illegal,
   input logic [VL_W-1:0]      cfg_vl,
   input logic [2:0]           cfg_sew_code,
   input logic [2:0]           cfg_lmul_code,
   input logic                 cfg_tail_agn,
   input logic                 cfg_mask_agn,
   input logic [REG_IDX_W-1:0] grp_base,
   input logic                 grp_aligned
);
   logic [7:0] cfg_packed;
   assign cfg_packed = {cfg_mask_agn, cfg_tail_agn, cfg_sew_code, cfg_lmul_code};

   // R2 / R8: granted length never exceeds the request
   a_r2_not_above_request: assert property (@(posedge clk) disable iff (!rst_n)
      req_valid |-> (CW'(rd_vl) <= CW'(req_avl)));

   // R3: fractional legal groups hold at most half a register of bytes
   a_r3_frac_cap: assert property (@(posedge clk) disable iff (!rst_n)
      (req_valid && req_vtype[2] && req_vtype[1:0] != 2'b00 && !req_illegal)
      |-> (CW'(rd_vl) <= CW'(VLEN / 16)));

   // R4: reserved immediates are rejected with zero length
   a_r4_reserved: assert property (@(posedge clk) disable iff (!rst_n)
      (req_valid && (req_vtype[2:0] == 3'b100 || req_vtype[5]))
      |-> (req_illegal && rd_vl == '0));

   // R5: legal request commits length and type
   a_r5_commit: assert property (@(posedge clk) disable iff (!rst_n)
      (req_valid && !req_illegal)
      |=> (cfg_vl == $past(rd_vl) && cfg_packed == $past(req_vtype)));

   // R6: illegal request zeroes length and keeps type
   a_r6_keep_type: assert property (@(posedge clk) disable iff (!rst_n)
      (req_valid && req_illegal) |=> (cfg_vl == '0 && $stable(cfg_packed)));

   // R7: idle cycles hold state
   a_r7_hold: assert property (@(posedge clk) disable iff (!rst_n)
      !req_valid |=> ($stable(cfg_vl) && $stable(cfg_packed)));

   // R8: zero request grants zero
   a_r8_zero_req: assert property (@(posedge clk) disable iff (!rst_n)
      (req_valid && req_avl == '0) |-> (rd_vl == '0));

   // R9: group of eight accepts only multiples of eight
   a_r9_align_eight: assert property (@(posedge clk) disable iff (!rst_n)
      (grp_aligned && cfg_lmul_code == 3'b011) |-> (grp_base[2:0] == 3'b000));
endmodule

bind vcfg_unit vcfg_unit_chk #(.VLEN(VLEN), .AVL_W(AVL_W), .REG_IDX_W(REG_IDX_W)) chk_i (
   .clk(clk), .rst_n(rst_n), .req_valid(req_valid), .req_avl(req_avl),
   .req_vtype(req_vtype), .rd_vl(rd_vl), .req_illegal(req_illegal),
   .cfg_vl(cfg_vl), .cfg_sew_code(cfg_sew_code), .cfg_lmul_code(cfg_lmul_code),
   .cfg_tail_agn(cfg_tail_agn), .cfg_mask_agn(cfg_mask_agn),
   .grp_base(grp_base), .grp_aligned(grp_aligned)
);

// File: tb/vcfg_unit_tb_top.sv
`timescale 1ns/100ps
module vcfg_unit_tb_top;
   localparam int unsigned VLEN  = 128;
   localparam int unsigned AVL_W = 10;
   localparam int unsigned VL_W  = $clog2(VLEN) + 1;

   logic             clk = 1'b0;
   logic             rst_n = 1'b0;
   logic             req_valid = 1'b0;
   logic [AVL_W-1:0] req_avl = '0;
   logic [7:0]       req_vtype = '0;
   logic [4:0]       grp_base = '0;
   logic [VL_W-1:0]  rd_vl, cfg_vl;
   logic             req_illegal, cfg_tail_agn, cfg_mask_agn, grp_aligned;
   logic [2:0]       cfg_sew_code, cfg_lmul_code;
   logic [9:0]       rd_vl_256, cfg_vl_256;
   logic             ill_256, ta256, ma256, ga256;
   logic [2:0]       sew256, lm256;

   int n_chk = 0;
   int n_fail = 0;
   int m_vl = 0;
   logic [7:0] m_type = 8'h00;

   always #2.5 clk = ~clk;

   vcfg_unit #(.VLEN(VLEN), .AVL_W(AVL_W)) dut_i (
      .clk(clk), .rst_n(rst_n), .req_valid(req_valid), .req_avl(req_avl),
      .req_vtype(req_vtype), .rd_vl(rd_vl), .req_illegal(req_illegal),
      .cfg_vl(cfg_vl), .cfg_sew_code(cfg_sew_code), .cfg_lmul_code(cfg_lmul_code),
      .cfg_tail_agn(cfg_tail_agn), .cfg_mask_agn(cfg_mask_agn),
      .grp_base(grp_base), .grp_aligned(grp_aligned));

   vcfg_unit #(.VLEN(256), .AVL_W(AVL_W), .VLMAX_STYLE(1)) dut256_i (
      .clk(clk), .rst_n(rst_n), .req_valid(req_valid), .req_avl(req_avl),
      .req_vtype(req_vtype), .rd_vl(rd_vl_256), .req_illegal(ill_256),
      .cfg_vl(cfg_vl_256), .cfg_sew_code(sew256), .cfg_lmul_code(lm256),
      .cfg_tail_agn(ta256), .cfg_mask_agn(ma256),
      .grp_base(grp_base), .grp_aligned(ga256));

   task automatic chk(input bit ok, input string tag, input int act, input int exp);
      n_chk++;
      if (!ok) begin
         n_fail++;
         $display("FAIL %s: actual %0d expected %0d", tag, act, exp);
      end
   endtask

   // expected maximum; 0 means illegal
   function automatic int exp_max(input int vlen, input logic [7:0] t);
      int s, l;
      s = int'(t[5:3]);
      l = int'(t[2:0]);
      if (t[5] || l == 4) return 0;
      if (l < 4) return (vlen >> (s + 3)) << l;
      return vlen >> (s + 3 + 8 - l);
   endfunction

   task automatic check_state(input string tag);
      chk(cfg_vl == VL_W'(m_vl), {tag, " vl"}, int'(cfg_vl), m_vl);
      chk({cfg_mask_agn, cfg_tail_agn, cfg_sew_code, cfg_lmul_code} == m_type,
          {tag, " type"}, int'({cfg_mask_agn, cfg_tail_agn, cfg_sew_code, cfg_lmul_code}),
          int'(m_type));
   endtask

   // called just after a falling edge; returns just after the next one
   task automatic step(input bit v, input int cnt, input logic [7:0] t);
      int mx, ev;
      req_valid = v;
      req_avl   = AVL_W'(cnt);
      req_vtype = t;
      mx = exp_max(VLEN, t);
      ev = (mx == 0) ? 0 : ((cnt < mx) ? cnt : mx);
      #1;
      if (t[5] || t[2:0] == 3'b100)
         chk(req_illegal && rd_vl == '0, "R4 reserved", int'(req_illegal), 1);
      else if (t[2])
         chk(req_illegal == (mx == 0), "R3 frac illegal", int'(req_illegal), int'(mx == 0));
      chk(int'(rd_vl) == ev, cnt == 0 ? "R8 zero req" : (t[2] ? "R3 frac vl" : "R2 vl"),
          int'(rd_vl), ev);
      if (cnt == 0 && mx != 0)
         chk(!req_illegal, "R8 zero not illegal", int'(req_illegal), 0);
      @(negedge clk);
      if (v) begin
         m_vl = ev;
         if (mx != 0) m_type = t;
      end
      check_state(v ? (mx == 0 ? "R6 illegal commit" : "R5 commit") : "R7 hold");
   endtask

   initial begin
      repeat (200000) @(posedge clk);
      n_fail++;
      $display("FAIL watchdog: actual %0d expected %0d", 200000, 0);
      $display("  End of test - %0d assertions evaluated, %0d failures", n_chk, n_fail);
      $finish;
   end

   initial begin
      repeat (3) @(negedge clk);
      chk(cfg_vl == '0, "R1 reset vl", int'(cfg_vl), 0);
      chk({cfg_mask_agn, cfg_tail_agn, cfg_sew_code, cfg_lmul_code} == 8'h00,
          "R1 reset type", int'(cfg_sew_code), 0);
      rst_n = 1'b1;
      @(negedge clk);
      check_state("R1 after release");

      // R2 stated example on the 256-bit instance: e32, group 1, request 100
      req_valid = 1'b0; req_avl = AVL_W'(100); req_vtype = 8'h10; #1;
      chk(rd_vl_256 == 10'd8, "R2 example 256", int'(rd_vl_256), 8);
      chk(rd_vl == VL_W'(4), "R2 example 128", int'(rd_vl), 4);
      @(negedge clk);
      check_state("R7 hold idle");

      for (int t = 0; t < 256; t++) begin
         int mx;
         logic [7:0] tv;
         tv = 8'(t);
         mx = exp_max(VLEN, tv);
         if (mx == 0) begin
            step(1'b1, 5, tv);
            step(1'b1, 0, tv);
            step(1'b1, 1023, tv);
         end else begin
            step(1'b1, 0, tv);
            step(1'b1, 1, tv);
            step(1'b1, mx - 1, tv);
            step(1'b1, mx + 1, tv);
            step(1'b1, 1023, tv);
            step(1'b1, mx, tv);
            // R9: sweep group bases against the committed multiplier
            for (int b = 0; b < 32; b++) begin
               bit ea;
               grp_base = 5'(b);
               #0.2;
               ea = (tv[2:0] >= 3'd1 && tv[2:0] <= 3'd3) ? ((b % (1 << tv[2:0])) == 0) : 1'b1;
               chk(grp_aligned == ea, "R9 group align", int'(grp_aligned), int'(ea));
            end
         end
         step(1'b0, 7, ~tv);
      end

      $display("  End of test - %0d assertions evaluated, %0d failures", n_chk, n_fail);
      $finish;
   end
endmodule